// File: doc/BRIEF.md
# Bus Cycle Termination Arbiter

This block ends each bus cycle that a bus master starts. The host requests a cycle with an address and attributes. The block drives that cycle onto the bus and then watches the slave's response lines: a two-bit data acknowledge, a bus-error line and a halt line. It samples these lines at two clock edges, one clock apart. From the pair of samples it picks one outcome: normal completion, completion followed by a hold-off, a bus-error exception request to the host, or an automatic retry of the same cycle.

A built-in watchdog counter raises an internal bus error when a cycle gets no acknowledge and no error within a programmable number of clocks. This covers accesses that nobody decodes. A retry counter sets an upper bound on how many times one cycle can be retried. When that bound is reached, the cycle becomes a bus error and an error flag is raised.

Top module: `bus_term_arb`

## Requirements
- R1: After reset, every outcome pulse, `stall` and `bus_req` are low.
- R2: A `cyc_start` seen in the idle state latches `cyc_addr`/`cyc_attr` onto `bus_addr`/`bus_attr` and raises `bus_req` on the next clock. A `cyc_start` seen while a cycle is active or held is ignored, and `bus_addr` does not change.
- R3: The first sample is the clock edge, while the cycle is waiting, at which `ack_in` is nonzero, `berr_in` is high or the watchdog expires. The second sample is the edge one clock later. If `ack_in` was nonzero and neither sample saw `berr_in` or `halt_in`, `done_p` pulses for one clock after the second sample and `bus_req` falls.
- R4: If `ack_in` was seen and `halt_in` was high at either sample, with no bus error at either sample, `halted_p` pulses instead. `stall` then stays high until an edge that samples `halt_in` low. After that edge `stall` and `bus_req` are low.
- R5: A bus error at either sample with `halt_in` low at both samples pulses `berr_exc_p`. This includes an error that first appears at the second sample, after an acknowledge at the first.
- R6: A bus error at either sample together with `halt_in` at either sample pulses `retry_p` and raises `stall`. On the edge that samples `halt_in` low, the cycle is reissued with the same `bus_addr`/`bus_attr` and `bus_req` rises again.
- R7: A bus error overrides an acknowledge: a cycle that sees `berr_in` never pulses `done_p` or `halted_p`.
- R8: With `tmo_limit`=L>0, a cycle that gets no acknowledge and no error takes its first sample on the (L+1)th waiting edge, with a bus error forced in. `berr_exc_p` therefore pulses L+2 clocks after the start edge. L=0 turns the watchdog off.
- R9: A cycle can be retried at most RETRY_MAX times. The retry outcome that would exceed this limit pulses `berr_exc_p` and `retry_err_p` together and releases the bus. The count clears on every new start.
- R10: The outcome pulses `done_p`, `halted_p`, `berr_exc_p` and `retry_p` are mutually exclusive and last one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_start | input | 1 | Request a new bus cycle |
| cyc_addr | input | ADDR_W | Address of the requested cycle |
| cyc_attr | input | ATTR_W | Attributes of the requested cycle |
| tmo_limit | input | TMO_W | Watchdog limit in clocks, 0 turns it off |
| ack_in | input | 2 | Data acknowledge from the slave, any nonzero value counts |
| berr_in | input | 1 | Bus error from the slave |
| halt_in | input | 1 | Halt request from the system |
| bus_req | output | 1 | Cycle active on the bus |
| bus_addr | output | ADDR_W | Address driven for the current cycle |
| bus_attr | output | ATTR_W | Attributes driven for the current cycle |
| done_p | output | 1 | Normal completion pulse |
| halted_p | output | 1 | Completion followed by a halt hold-off |
| berr_exc_p | output | 1 | Bus-error exception request |
| retry_p | output | 1 | Retry scheduled |
| retry_err_p | output | 1 | Retry limit exceeded |
| stall | output | 1 | Master held off by halt |

## Verification
The bench builds the block with a 16-bit address, a 4-bit attribute, an 8-bit watchdog and RETRY_MAX set to 2. The low retry limit means random runs of back-to-back error-and-halt responses often reach the overflow case, rather than only in a directed test. The narrow watchdog lets the expiry path and the setting that turns it off both be reached in a few dozen clocks.

// File: rtl/bta_pkg.sv
package bta_pkg;

   typedef struct packed {
      logic ack;
      logic berr;
      logic halt;
   } samp_t;

   typedef enum logic [1:0] {
      OC_DONE  = 2'd0,
      OC_HALT  = 2'd1,
      OC_BERR  = 2'd2,
      OC_RETRY = 2'd3
   } outcome_t;

   typedef enum logic [2:0] {
      S_IDLE   = 3'd0,
      S_WAIT   = 3'd1,
      S_DECIDE = 3'd2,
      S_HOLD   = 3'd3,
      S_RHOLD  = 3'd4
   } state_t;

   // Error wins over acknowledge; halt turns error into retry and completion into hold-off.
   function automatic outcome_t classify(input samp_t first, input samp_t second);
      logic any_err;
      logic any_halt;
      any_err  = first.berr | second.berr;
      any_halt = first.halt | second.halt;
      if (any_err)
         return any_halt ? OC_RETRY : OC_BERR;
      else if (any_halt)
         return OC_HALT;
      else
         return OC_DONE;
   endfunction

endpackage

// File: rtl/bta_timer.sv
module bta_timer #(
   parameter int TMO_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic [TMO_W-1:0] limit,
   output logic             expired
);
   logic [TMO_W-1:0] cnt_q;

   assign expired = active && (limit != '0) && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!active)
         cnt_q <= '0;
      else if (!expired)
         cnt_q <= cnt_q + 1'b1;
   end

   // R8: expiry ends the waiting phase, so it never lasts two clocks
   p_expire_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
      expired |=> !expired);

endmodule

// File: rtl/bta_sampler.sv
module bta_sampler
   import bta_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       capture,
   input  logic       force_berr,
   input  logic [1:0] ack_in,
   input  logic       berr_in,
   input  logic       halt_in,
   output outcome_t   outcome
);
   samp_t first_q;
   samp_t second_now;

   always_comb begin
      second_now.ack  = |ack_in;
      second_now.berr = berr_in;
      second_now.halt = halt_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         first_q <= '0;
      else if (capture) begin
         first_q.ack  <= |ack_in;
         first_q.berr <= berr_in | force_berr;
         first_q.halt <= halt_in;
      end
   end

   assign outcome = classify(first_q, second_now);

endmodule

// File: rtl/bta_retry_ctr.sv
module bta_retry_ctr #(
   parameter int RETRY_MAX = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic at_max
);
   localparam int CW = $clog2(RETRY_MAX + 1);

   logic [CW-1:0] cnt_q;

   assign at_max = (cnt_q == CW'(RETRY_MAX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (inc && !at_max)
         cnt_q <= cnt_q + 1'b1;
   end

   // R9: the retry count never passes its limit
   p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(RETRY_MAX));

endmodule

// File: rtl/bus_term_arb.sv
module bus_term_arb
   import bta_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int ATTR_W    = 4,
   parameter int TMO_W     = 8,
   parameter int RETRY_MAX = 3,
   parameter bit USE_TIMER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_start,
   input  logic [ADDR_W-1:0] cyc_addr,
   input  logic [ATTR_W-1:0] cyc_attr,
   input  logic [TMO_W-1:0]  tmo_limit,
   input  logic [1:0]        ack_in,
   input  logic              berr_in,
   input  logic              halt_in,
   output logic              bus_req,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [ATTR_W-1:0] bus_attr,
   output logic              done_p,
   output logic              halted_p,
   output logic              berr_exc_p,
   output logic              retry_p,
   output logic              retry_err_p,
   output logic              stall
);
   generate
      if (ADDR_W < 1)                 begin : g_bad_addr  $error("ADDR_W must be positive"); end
      if (ATTR_W < 1)                 begin : g_bad_attr  $error("ATTR_W must be positive"); end
      if (TMO_W < 1 || TMO_W > 32)    begin : g_bad_tmo   $error("TMO_W out of range"); end
      if (RETRY_MAX < 1)              begin : g_bad_retry $error("RETRY_MAX must be at least 1"); end
   endgenerate

   state_t   st_q;
   outcome_t outcome;
   logic     tmo_exp;
   logic     waiting;
   logic     trig;
   logic     at_max;
   logic     rc_clr;
   logic     rc_inc;

   assign waiting = (st_q == S_WAIT);

   generate
      if (USE_TIMER) begin : g_timer
         bta_timer #(.TMO_W(TMO_W)) u_timer (
            .clk     (clk),
            .rst_n   (rst_n),
            .active  (waiting),
            .limit   (tmo_limit),
            .expired (tmo_exp)
         );
      end else begin : g_no_timer
         assign tmo_exp = 1'b0;
      end
   endgenerate

   assign trig = waiting && ((|ack_in) || berr_in || tmo_exp);

   bta_sampler u_sampler (
      .clk        (clk),
      .rst_n      (rst_n),
      .capture    (trig),
      .force_berr (tmo_exp),
      .ack_in     (ack_in),
      .berr_in    (berr_in),
      .halt_in    (halt_in),
      .outcome    (outcome)
   );

   assign rc_clr = (st_q == S_IDLE) && cyc_start;
   assign rc_inc = (st_q == S_DECIDE) && (outcome == OC_RETRY);

   bta_retry_ctr #(.RETRY_MAX(RETRY_MAX)) u_retry (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (rc_clr),
      .inc    (rc_inc),
      .at_max (at_max)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= S_IDLE;
         bus_addr    <= '0;
         bus_attr    <= '0;
         done_p      <= 1'b0;
         halted_p    <= 1'b0;
         berr_exc_p  <= 1'b0;
         retry_p     <= 1'b0;
         retry_err_p <= 1'b0;
      end else begin
         done_p      <= 1'b0;
         halted_p    <= 1'b0;
         berr_exc_p  <= 1'b0;
         retry_p     <= 1'b0;
         retry_err_p <= 1'b0;
         unique case (st_q)
            S_IDLE: if (cyc_start) begin
               bus_addr <= cyc_addr;
               bus_attr <= cyc_attr;
               st_q     <= S_WAIT;
            end
            S_WAIT: if (trig) st_q <= S_DECIDE;
            S_DECIDE: begin
               unique case (outcome)
                  OC_DONE: begin
                     done_p <= 1'b1;
                     st_q   <= S_IDLE;
                  end
                  OC_HALT: begin
                     halted_p <= 1'b1;
                     st_q     <= S_HOLD;
                  end
                  OC_BERR: begin
                     berr_exc_p <= 1'b1;
                     st_q       <= S_IDLE;
                  end
                  OC_RETRY: begin
                     if (at_max) begin
                        berr_exc_p  <= 1'b1;
                        retry_err_p <= 1'b1;
                        st_q        <= S_IDLE;
                     end else begin
                        retry_p <= 1'b1;
                        st_q    <= S_RHOLD;
                     end
                  end
               endcase
            end
            S_HOLD:  if (!halt_in) st_q <= S_IDLE;
            S_RHOLD: if (!halt_in) st_q <= S_WAIT;
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign bus_req = (st_q == S_WAIT) || (st_q == S_DECIDE);
   assign stall   = (st_q == S_HOLD) || (st_q == S_RHOLD);

   // R10: at most one outcome per cycle
   p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_p, halted_p, berr_exc_p, retry_p}));
   // R10: outcomes are single-clock pulses
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_p |=> !done_p);
   // R9: retry overflow is reported as a bus error
   p_overflow_berr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      retry_err_p |-> berr_exc_p);
   // R2: the driven address holds for the whole life of a cycle
   p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req || stall) |=> $stable(bus_addr) && $stable(bus_attr));
   // R4: halt keeps the master stalled
   p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && halt_in) |=> stall);
   // R6: a retry is followed by a stall
   p_retry_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      retry_p |-> stall);

endmodule

// File: tb/bus_term_arb_bench.sv
module bus_term_arb_bench;
   localparam int AW = 16;
   localparam int TW = 4;
   localparam int MW = 8;
   localparam int RMAX = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cyc_start = 1'b0;
   logic [AW-1:0] cyc_addr = '0;
   logic [TW-1:0] cyc_attr = '0;
   logic [MW-1:0] tmo_limit = 8'd200;
   logic [1:0]    ack_in = 2'b00;
   logic          berr_in = 1'b0;
   logic          halt_in = 1'b0;
   logic          bus_req, done_p, halted_p, berr_exc_p, retry_p, retry_err_p, stall;
   logic [AW-1:0] bus_addr;
   logic [TW-1:0] bus_attr;

   int total = 0;
   int bad = 0;
   int rc = 0;
   logic [AW-1:0] cur_addr = '0;
   logic [TW-1:0] cur_attr = '0;
   logic pending = 1'b0;

   always #2.5 clk = ~clk;

   bus_term_arb #(.ADDR_W(AW), .ATTR_W(TW), .TMO_W(MW), .RETRY_MAX(RMAX)) u_bus_term_arb (
      .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_addr(cyc_addr),
      .cyc_attr(cyc_attr), .tmo_limit(tmo_limit), .ack_in(ack_in), .berr_in(berr_in),
      .halt_in(halt_in), .bus_req(bus_req), .bus_addr(bus_addr), .bus_attr(bus_attr),
      .done_p(done_p), .halted_p(halted_p), .berr_exc_p(berr_exc_p), .retry_p(retry_p),
      .retry_err_p(retry_err_p), .stall(stall));

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // 0 done, 1 halt, 2 bus error, 3 retry
   function automatic int expect_oc(logic ea, logic ha, logic eb, logic hb);
      if (ea || eb) return (ha || hb) ? 3 : 2;
      if (ha || hb) return 1;
      return 0;
   endfunction

   function automatic logic [4:0] pulses_now();
      return {done_p, halted_p, berr_exc_p, retry_p, retry_err_p};
   endfunction

   task automatic start_cycle(input logic [AW-1:0] a, input logic [TW-1:0] t);
      cyc_start = 1'b1; cyc_addr = a; cyc_attr = t;
      tick;
      cyc_start = 1'b0;
      cur_addr = a; cur_attr = t; rc = 0;
      check("R2 bus_req after start", 32'(bus_req), 32'd1);
      check("R2 address latched", 32'(bus_addr), 32'(a));
   endtask

   task automatic trial(input logic [1:0] aa, input logic ea, input logic ha,
                        input logic [1:0] ab, input logic eb, input logic hb);
      int oc;
      logic [4:0] exp_p;
      if (!pending) start_cycle(16'($urandom), 4'($urandom));
      ack_in = aa; berr_in = ea; halt_in = ha;
      tick;
      check("R10 no outcome at first sample", 32'(pulses_now()), 32'd0);
      ack_in = ab; berr_in = eb; halt_in = hb;
      tick;
      oc = expect_oc(ea, ha, eb, hb);
      pending = 1'b0;
      case (oc)
         0: exp_p = 5'b10000;
         1: exp_p = 5'b01000;
         2: exp_p = 5'b00100;
         default: begin
            if (rc == RMAX) exp_p = 5'b00101;
            else begin exp_p = 5'b00010; rc++; pending = 1'b1; end
         end
      endcase
      if (oc == 0) check("R3 completion pulses", 32'(pulses_now()), 32'(exp_p));
      else if (oc == 1) check("R4 halt pulses", 32'(pulses_now()), 32'(exp_p));
      else if (oc == 2) check("R5 R7 bus error pulses", 32'(pulses_now()), 32'(exp_p));
      else check("R6 R9 retry pulses", 32'(pulses_now()), 32'(exp_p));
      ack_in = 2'b00; berr_in = 1'b0;
      if (oc == 1 || pending) begin
         check("R4 R6 stall after halt outcome", 32'(stall), 32'd1);
         halt_in = 1'b1;
         tick;
         check("R4 stall held by halt", 32'(stall), 32'd1);
         halt_in = 1'b0;
         tick;
         check("R4 R6 stall released", 32'(stall), 32'd0);
         if (pending) begin
            check("R6 reissue bus_req", 32'(bus_req), 32'd1);
            check("R6 reissue address", 32'({bus_addr, bus_attr}), 32'({cur_addr, cur_attr}));
         end else
            check("R4 bus released", 32'(bus_req), 32'd0);
      end else begin
         halt_in = 1'b0;
         check("R3 R5 bus released", 32'(bus_req), 32'd0);
         tick;
         check("R10 pulse lasts one clock", 32'(pulses_now()), 32'd0);
      end
   endtask

   initial begin
      int wd = 0;
      while (wd < 100000) begin @(posedge clk); wd++; end
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", wd, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      tick; tick;
      check("R1 reset outputs", 32'({pulses_now(), stall, bus_req}), 32'd0);
      rst_n = 1'b1;
      tick;
      check("R1 idle after reset", 32'({pulses_now(), stall, bus_req}), 32'd0);

      // R2: start during an active cycle is ignored
      start_cycle(16'hA5A5, 4'h3);
      cyc_start = 1'b1; cyc_addr = 16'h1234; cyc_attr = 4'hC;
      tick;
      cyc_start = 1'b0;
      check("R2 busy start ignored", 32'({bus_addr, bus_attr}), 32'h000A5A53);
      pending = 1'b1;
      trial(2'b01, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0);            // R3 plain ack

      trial(2'b10, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0);            // R5 late error after ack
      trial(2'b11, 1'b1, 1'b0, 2'b11, 1'b0, 1'b0);            // R7 error with ack
      trial(2'b01, 1'b0, 1'b1, 2'b01, 1'b0, 1'b1);            // R4 ack with halt
      // R9: retry twice then overflow
      trial(2'b00, 1'b1, 1'b1, 2'b00, 1'b1, 1'b1);
      trial(2'b01, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1);            // R6 halt joins late error
      trial(2'b00, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0);

      // R8: watchdog expiry
      tmo_limit = 8'd5;
      start_cycle(16'h00F0, 4'h1);
      for (int i = 0; i < 6; i++) tick;
      check("R8 no error before expiry", 32'({pulses_now(), bus_req}), 32'h1);
      tick;
      check("R8 expiry gives bus error", 32'(pulses_now()), 32'b00100);
      tick;

      // R8: watchdog off
      tmo_limit = 8'd0;
      start_cycle(16'h0F0F, 4'h2);
      for (int i = 0; i < 40; i++) tick;
      check("R8 disabled watchdog keeps waiting", 32'({pulses_now(), bus_req}), 32'h1);
      pending = 1'b1;
      trial(2'b01, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0);
      tmo_limit = 8'd200;

      for (int n = 0; n < 300; n++) begin
         logic [1:0] aa, ab;
         logic ea, ha, eb, hb;
         aa = 2'($urandom); ea = 1'($urandom); ha = 1'($urandom);
         ab = 2'($urandom); eb = 1'($urandom); hb = 1'($urandom);
         if (aa == 2'b00 && !ea) aa = 2'b01;
         if (n % 4 == 0) begin ea = 1'b1; ha = 1'b1; end
         trial(aa, ea, ha, ab, eb, hb);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule